// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block converts a single internal read or write request into one cycle on an external memory bus. It takes the timing of that cycle from a set of configuration inputs, so one sequencer can serve slow and fast memories. The configuration chooses between two bus arrangements. In the shared arrangement, address and data use one port in turn, and an address latch strobe separates them. In the separate arrangement, the address stays on its own port while data uses the data port. The data bus is 8 or 16 bits wide.

A cycle runs through fixed phases: address strobe, address hold, an optional strobe delay, the read or write strobe with its programmed wait states and optional READY extension, an optional bus-turnaround cycle, and a one-clock finish. The configuration bits stretch the address strobe and hold phases, add wait states, postpone the strobe, release a write strobe early, insert a turnaround cycle and enable the READY handshake. All of them are captured when a request is accepted, so they can change between cycles without upsetting the cycle in progress. The block also steers bytes onto the correct lanes, drives the upper-lane control in one of two styles, and masks the segment address outputs to the configured number of lines.

Top module: `ext_bus_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, `rd_n`, `wr_n` and `bhe_n` are high, and `ale`, `done`, `ad_oe` and `seg_o` are all zero.
- R2: An accepted request starts with `ale` high for 1 clock, or 2 clocks when `cfg_ale_ext`=1. An address hold phase of the same length follows. When `cfg_mux`=1, the address low 16 bits sit on `ad_o` with `ad_oe`=1 during both phases and `addr_o` is 0. When `cfg_mux`=0, `addr_o` carries the address for the whole cycle.
- R3: The strobe (`rd_n` low for a read, `wr_n` low for a write) lasts 2+`cfg_wait` clocks when READY is not used. The whole cycle, from the first `ale` clock through the `done` clock, lasts 2·(1+ale_ext) + rw_delay + (2+wait) + (1−tri_nowait) + 1 clocks.
- R4: `cfg_rw_delay`=1 inserts one clock with both strobes high between the hold phase and the strobe.
- R5: `cfg_tri_nowait`=0 inserts one clock after the strobe with strobes high and `ad_oe`=0. `cfg_tri_nowait`=1 inserts nothing.
- R6: With `cfg_early_wr`=1, the write strobe goes high one clock earlier than the read strobe would, so it lasts 1+`cfg_wait` clocks.
- R7: With `cfg_rdy_en`=1, `rdy_n` (low = ready) is sampled only after the wait count has run out. The strobe then lasts until a clock edge finds `rdy_n` low, so it is 2+wait+K clocks when `rdy_n` is high for K extra edges. A low `rdy_n` during the wait states does not shorten the cycle. With `cfg_rdy_en`=0, `rdy_n` has no effect.
- R8: On a 16-bit bus (`cfg_bus16`=1), a byte write drives `req_wdata[7:0]` on both halves of `ad_o`, and a word write drives `req_wdata`. A byte read returns `ad_in[15:8]` when address bit 0 is 1 and `ad_in[7:0]` when it is 0, zero-extended in `rdata`. A word read returns `ad_in` unchanged.
- R9: With `cfg_lane_strb`=0, `bhe_n` is low for the whole busy period when the upper lane is used (16-bit bus, and either a word access or address bit 0 = 1). With `cfg_lane_strb`=1 on writes, `wr_n` acts as the low-lane write strobe and `bhe_n` as the high-lane write strobe. Each follows the write-strobe timing only for the lane it serves.
- R10: While busy, `seg_o` carries the request address bits 22:16, masked by `cfg_seg_code`: 11 keeps 2 lines, 10 keeps 7 lines, 01 keeps none, 00 keeps 4 lines.
- R11: `done` is high for exactly one clock, the last clock of the cycle, and `busy` is low on the next clock. The configuration and request are captured at acceptance, so later changes to the configuration do not affect the running cycle.
- R12: On an 8-bit bus (`cfg_bus16`=0), every access is a byte access on `ad_o[7:0]` with `ad_o[15:8]`=0, reads take `ad_in[7:0]`, and `bhe_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; accepted when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| cfg_mux | input | 1 | 1 = shared address/data port |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus |
| cfg_ale_ext | input | 1 | Stretch address strobe and hold by one clock each |
| cfg_wait | input | WAIT_W | Wait states added to the strobe |
| cfg_tri_nowait | input | 1 | 0 = add a turnaround clock after the strobe |
| cfg_rw_delay | input | 1 | 1 = delay the strobe by one clock |
| cfg_early_wr | input | 1 | 1 = release the write strobe one clock early |
| cfg_rdy_en | input | 1 | 1 = extend the strobe with `rdy_n` |
| cfg_lane_strb | input | 1 | 1 = per-lane write strobes on `wr_n`/`bhe_n` |
| cfg_seg_code | input | 2 | Segment line count code |
| rdy_n | input | 1 | Ready from memory, active low |
| ad_in | input | 16 | Data read from the bus |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse at the end of a cycle |
| rdata | output | 16 | Read result, valid from `done` |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe or low-lane write strobe, active low |
| bhe_n | output | 1 | Upper-lane enable or high-lane write strobe, active low |
| addr_o | output | 16 | Separate address port |
| ad_o | output | 16 | Data port, or shared address/data port |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| seg_o | output | 7 | Segment address lines |

## Verification
The assertions assume that requests arrive only while `busy` is low, or are otherwise ignored. They also assume that `rdy_n` eventually goes low when the READY handshake is on, and that lane-strobe mode is used only with a 16-bit bus. The bench raises `req_valid` for exactly one clock and only after the previous `done`. It releases `rdy_n` after a chosen count of strobe clocks, and it selects lane-strobe mode only with `cfg_bus16`=1. Configuration inputs are changed mid-cycle only in the test that shows they are captured at acceptance.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [23:0]       req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              cfg_mux,
  input  logic              cfg_bus16,
  input  logic              cfg_ale_ext,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_tri_nowait,
  input  logic              cfg_rw_delay,
  input  logic              cfg_early_wr,
  input  logic              cfg_rdy_en,
  input  logic              cfg_lane_strb,
  input  logic [1:0]        cfg_seg_code,
  input  logic              rdy_n,
  input  logic [15:0]       ad_in,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bhe_n,
  output logic [15:0]       addr_o,
  output logic [15:0]       ad_o,
  output logic              ad_oe,
  output logic [6:0]        seg_o
);
  localparam int CW = WAIT_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_ALE, S_HOLD, S_DLY, S_STRB, S_TRI, S_FIN} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic l_wr, l_byte, l_mux, l_b16, l_ext, l_tnw, l_rwd, l_early, l_rdy, l_lane;
  logic [WAIT_W-1:0] l_wait;
  logic [1:0] l_seg;
  logic [23:0] l_addr;
  logic [15:0] l_wd;

  logic lo_lane, hi_lane, strb, wr_act, addr_ph, last_cnt;
  logic [15:0] rd_pick, wd_out;
  logic [6:0] seg_mask;

  assign last_cnt = (cnt == '0);
  assign lo_lane  = !l_b16 || !l_byte || !l_addr[0];
  assign hi_lane  = l_b16 && (!l_byte || l_addr[0]);
  assign rd_pick  = !l_b16 ? {8'h00, ad_in[7:0]} :
                    l_byte ? {8'h00, (l_addr[0] ? ad_in[15:8] : ad_in[7:0])} : ad_in;
  assign wd_out   = !l_b16 ? {8'h00, l_wd[7:0]} :
                    l_byte ? {2{l_wd[7:0]}} : l_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      {l_wr, l_byte, l_mux, l_b16, l_ext, l_tnw, l_rwd, l_early, l_rdy, l_lane} <= '0;
      l_wait <= '0;
      l_seg <= '0;
      l_addr <= '0;
      l_wd <= '0;
      rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st <= S_ALE;
          cnt <= CW'(cfg_ale_ext);
          l_wr <= req_write;
          l_byte <= req_byte || !cfg_bus16;
          l_mux <= cfg_mux;
          l_b16 <= cfg_bus16;
          l_ext <= cfg_ale_ext;
          l_tnw <= cfg_tri_nowait;
          l_rwd <= cfg_rw_delay;
          l_early <= cfg_early_wr;
          l_rdy <= cfg_rdy_en;
          l_lane <= cfg_lane_strb;
          l_wait <= cfg_wait;
          l_seg <= cfg_seg_code;
          l_addr <= req_addr;
          l_wd <= req_wdata;
        end
        S_ALE: if (last_cnt) begin
          st <= S_HOLD;
          cnt <= CW'(l_ext);
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (!last_cnt) cnt <= cnt - 1'b1;
          else if (l_rwd) st <= S_DLY;
          else begin
            st <= S_STRB;
            cnt <= CW'(l_wait) + CW'(1);
          end
        S_DLY: begin
          st <= S_STRB;
          cnt <= CW'(l_wait) + CW'(1);
        end
        S_STRB: if (!last_cnt) cnt <= cnt - 1'b1;
          else if (!(l_rdy && rdy_n)) begin
            if (!l_wr) rdata <= rd_pick;
            st <= l_tnw ? S_FIN : S_TRI;
          end
        S_TRI: st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (l_seg)
      2'b11:   seg_mask = 7'h03;
      2'b10:   seg_mask = 7'h7F;
      2'b01:   seg_mask = 7'h00;
      default: seg_mask = 7'h0F;
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign ale     = (st == S_ALE);
  assign strb    = (st == S_STRB);
  assign wr_act  = strb && l_wr && !(l_early && last_cnt);
  assign rd_n    = !(strb && !l_wr);
  assign wr_n    = l_lane ? !(wr_act && lo_lane) : !wr_act;
  assign bhe_n   = l_lane ? !(wr_act && hi_lane) : !(busy && hi_lane);
  assign addr_ph = l_mux && (st == S_ALE || st == S_HOLD);
  assign ad_oe   = busy && (addr_ph || (l_wr && (st == S_DLY || strb)));
  assign ad_o    = !ad_oe ? 16'h0000 : (addr_ph ? l_addr[15:0] : wd_out);
  assign addr_o  = (busy && !l_mux) ? l_addr[15:0] : 16'h0000;
  assign seg_o   = busy ? (l_addr[22:16] & seg_mask) : 7'h00;
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic        bhe_n,
  input logic        ad_oe,
  input logic [6:0]  seg_o
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && bhe_n && !ad_oe && !ale && !done));

  a_r10_seg_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (seg_o == 7'h00));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r2_start_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale);

  a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  a_r8_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  a_r3_one_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
endmodule

bind ext_bus_seq ext_bus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .ad_oe(ad_oe), .seg_o(seg_o)
);

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_byte = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic cfg_mux = 0, cfg_bus16 = 1, cfg_ale_ext = 0;
  logic [3:0] cfg_wait = 0;
  logic cfg_tri_nowait = 1, cfg_rw_delay = 0, cfg_early_wr = 0, cfg_rdy_en = 0, cfg_lane_strb = 0;
  logic [1:0] cfg_seg_code = 2'b10;
  logic rdy_n = 0;
  logic [15:0] ad_in = 16'hC3A5;
  logic busy, done, ale, rd_n, wr_n, bhe_n, ad_oe;
  logic [15:0] rdata, addr_o, ad_o;
  logic [6:0] seg_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ext_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_mux(cfg_mux), .cfg_bus16(cfg_bus16),
    .cfg_ale_ext(cfg_ale_ext), .cfg_wait(cfg_wait), .cfg_tri_nowait(cfg_tri_nowait),
    .cfg_rw_delay(cfg_rw_delay), .cfg_early_wr(cfg_early_wr), .cfg_rdy_en(cfg_rdy_en),
    .cfg_lane_strb(cfg_lane_strb), .cfg_seg_code(cfg_seg_code), .rdy_n(rdy_n), .ad_in(ad_in),
    .busy(busy), .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .bhe_n(bhe_n), .addr_o(addr_o), .ad_o(ad_o), .ad_oe(ad_oe), .seg_o(seg_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(string tag, bit wr, bit byt, logic [23:0] addr, logic [15:0] wd,
                     int k, bit disturb);
    int e = cfg_ale_ext, w = cfg_wait, d = cfg_rw_delay, t = cfg_tri_nowait;
    bit early = cfg_early_wr, rdy = cfg_rdy_en, b16 = cfg_bus16, mux = cfg_mux, lane = cfg_lane_strb;
    logic [1:0] sc = cfg_seg_code;
    logic [3:0] w_save = cfg_wait;
    bit eb = byt || !b16;
    int kx = rdy ? k : 0;
    int slen = 2 + w + kx;
    int wlen = early ? 1 + w : slen;
    bit lo = !b16 || !eb || !addr[0];
    bit hi = b16 && (!eb || addr[0]);
    int n = 0, n_ale = 0, n_rd = 0, n_wr = 0, n_bhe = 0, n_oe_ale = 0;
    int gap_lead = 0;
    logic [15:0] ad_at_ale = 0, addr_at_ale = 0, wdat = 0, rd_got = 0;
    logic [6:0] seg_got = 0;
    logic [6:0] msk;
    logic [15:0] exp_wd, exp_rd;
    bit seen_strb = 0, got_done = 0;
    msk = (sc == 2'b11) ? 7'h03 : (sc == 2'b10) ? 7'h7F : (sc == 2'b01) ? 7'h00 : 7'h0F;
    exp_wd = !b16 ? {8'h00, wd[7:0]} : eb ? {2{wd[7:0]}} : wd;
    exp_rd = !b16 ? {8'h00, ad_in[7:0]} : eb ? {8'h00, (addr[0] ? ad_in[15:8] : ad_in[7:0])} : ad_in;
    rdy_n = (k > 0);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_byte = byt; req_addr = addr; req_wdata = wd;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (c == 0) begin
        req_valid = 0;
        if (disturb) begin
          cfg_wait = ~w_save; cfg_tri_nowait = ~cfg_tri_nowait; cfg_rw_delay = ~cfg_rw_delay;
        end
      end
      n++;
      if (ale) begin
        n_ale++; ad_at_ale = ad_o; addr_at_ale = addr_o; seg_got = seg_o;
        if (ad_oe) n_oe_ale++;
      end
      if (!rd_n || (!wr_n && !lane) || (lane && (!wr_n || !bhe_n))) begin
        if (!seen_strb) begin gap_lead = n - 1; wdat = ad_o; end
        seen_strb = 1;
      end
      if (!rd_n) n_rd++;
      if (!wr_n) n_wr++;
      if (!bhe_n) n_bhe++;
      if (n_rd == 2 + w + k && !wr) rdy_n = 0;
      if (done) begin rd_got = rdata; got_done = 1; break; end
    end
    rdy_n = 0;
    if (disturb) begin cfg_wait = w_save; cfg_tri_nowait = t[0]; cfg_rw_delay = d[0]; end
    chk({tag, " R11 done seen"}, got_done, 1);
    chk({tag, " R3 cycle length"}, n, 2*(1+e) + d + slen + (t ? 0 : 1) + 1);
    chk({tag, " R2 ale length"}, n_ale, 1 + e);
    chk({tag, " R2 R4 strobe start"}, gap_lead, 2*(1+e) + d);
    chk({tag, " R2 shared port address"}, mux ? int'(ad_at_ale) : 0, mux ? int'(addr[15:0]) : 0);
    chk({tag, " R2 ad_oe in address phase"}, n_oe_ale, mux ? 1 + e : 0);
    chk({tag, " R2 separate address port"}, addr_at_ale, mux ? 16'h0 : addr[15:0]);
    chk({tag, " R10 segment lines"}, seg_got, addr[22:16] & msk);
    if (wr) begin
      chk({tag, " R3 R6 R9 write strobe low clocks"}, n_wr, (lane && !lo) ? 0 : wlen);
      chk({tag, " R3 no read strobe on write"}, n_rd, 0);
      chk({tag, " R8 R12 write data lanes"}, wdat, exp_wd);
    end else begin
      chk({tag, " R3 R7 read strobe low clocks"}, n_rd, slen);
      chk({tag, " R8 R12 read data"}, rd_got, exp_rd);
    end
    if (lane && wr) chk({tag, " R9 high-lane write strobe"}, n_bhe, hi ? wlen : 0);
    else            chk({tag, " R9 R12 upper byte enable"}, n_bhe, hi ? n : 0);
    @(negedge clk);
    chk({tag, " R1 R11 idle after done"}, {busy, done, rd_n, wr_n, bhe_n, ad_oe}, 6'b001110);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {busy, done, ale, rd_n, wr_n, bhe_n, ad_oe}, 7'b0001110);
    chk("R1 reset seg", seg_o, 0);
  endtask

  task automatic t_basic;
    cfg_mux = 1; run("mux word read", 0, 0, 24'h12_3456, 0, 0, 0);
    cfg_mux = 0; run("demux word write", 1, 0, 24'h05_8A3C, 16'hBEEF, 0, 0);
  endtask

  task automatic t_waits_ext;
    cfg_ale_ext = 1; cfg_wait = 4'd5; cfg_mux = 1;
    run("ext ale wait5 read", 0, 0, 24'h00_1230, 0, 0, 0);
    cfg_wait = 4'd15; run("wait15 write", 1, 0, 24'h00_0F00, 16'h1357, 0, 0);
    cfg_ale_ext = 0; cfg_wait = 0; cfg_mux = 0;
  endtask

  task automatic t_delay_tri;
    cfg_rw_delay = 1; cfg_tri_nowait = 0; cfg_wait = 4'd2;
    run("R4 R5 read", 0, 0, 24'h01_0002, 0, 0, 0);
    run("R4 R5 write", 1, 0, 24'h01_0004, 16'h4242, 0, 0);
    cfg_rw_delay = 0; cfg_tri_nowait = 1; cfg_wait = 0;
  endtask

  task automatic t_early;
    cfg_early_wr = 1; cfg_wait = 4'd3;
    run("R6 early write", 1, 0, 24'h00_2222, 16'h9876, 0, 0);
    cfg_wait = 0; run("R6 early write nowait", 1, 0, 24'h00_2224, 16'h1111, 0, 0);
    cfg_early_wr = 0;
  endtask

  task automatic t_ready;
    cfg_rdy_en = 1; cfg_wait = 4'd2;
    run("R7 ready late by 3", 0, 0, 24'h00_3000, 0, 3, 0);
    run("R7 ready low during waits", 0, 0, 24'h00_3002, 0, 0, 0);
    cfg_wait = 0; run("R7 ready late by 1 nowait", 0, 0, 24'h00_3004, 0, 1, 0);
    cfg_rdy_en = 0; cfg_wait = 4'd1;
    run("R7 ready disabled", 0, 0, 24'h00_3006, 0, 5, 0);
    cfg_wait = 0;
  endtask

  task automatic t_bytes;
    cfg_bus16 = 1;
    run("R8 byte write even", 1, 1, 24'h00_4000, 16'h77A1, 0, 0);
    run("R8 byte write odd", 1, 1, 24'h00_4001, 16'h55B2, 0, 0);
    run("R8 byte read odd", 0, 1, 24'h00_4003, 0, 0, 0);
    run("R8 byte read even", 0, 1, 24'h00_4004, 0, 0, 0);
    cfg_bus16 = 0;
    run("R12 bus8 read", 0, 0, 24'h00_5001, 0, 0, 0);
    run("R12 bus8 write", 1, 0, 24'h00_5002, 16'hABCD, 0, 0);
    cfg_bus16 = 1;
  endtask

  task automatic t_lanes;
    cfg_lane_strb = 1;
    run("R9 lane word write", 1, 0, 24'h00_6000, 16'h2468, 0, 0);
    run("R9 lane byte even", 1, 1, 24'h00_6002, 16'h0013, 0, 0);
    run("R9 lane byte odd", 1, 1, 24'h00_6003, 16'h0031, 0, 0);
    cfg_early_wr = 1; cfg_wait = 4'd2;
    run("R9 R6 lane early odd", 1, 1, 24'h00_6005, 16'h0044, 0, 0);
    cfg_early_wr = 0; cfg_wait = 0; cfg_lane_strb = 0;
  endtask

  task automatic t_segments;
    for (int i = 0; i < 4; i++) begin
      cfg_seg_code = 2'(i);
      run($sformatf("R10 seg code %0d", i), 0, 0, 24'h7F_0000, 0, 0, 0);
    end
    cfg_seg_code = 2'b10;
  endtask

  task automatic t_latch;
    cfg_wait = 4'd1;
    run("R11 config captured", 0, 0, 24'h00_7000, 0, 0, 1);
    cfg_wait = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_waits_ext();
    t_delay_tri();
    t_early();
    t_ready();
    t_bytes();
    t_lanes();
    t_segments();
    t_latch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule